// File: doc/BRIEF.md
# Compressed-Mode Instruction Stream Sequencer

This block sits right after instruction fetch. It takes aligned 16-bit parcels, one per handshake, and groups them into instructions of one or two parcels. An instruction's length does not come from its own bits. It comes from a mode mask that an earlier prefix instruction loaded.

A prefix is a two-parcel instruction. The top six bits of its first parcel equal the prefix opcode. The low ten bits of that parcel are the mode mask, and the second parcel is one compressed instruction carried inside the prefix. The mask bits are then used up one per following instruction, most significant bit first. A 1 marks a one-parcel compressed instruction; a 0 marks a two-parcel instruction. When no bits are left, every instruction takes two parcels.

A taken branch throws away the remaining bits, any half-assembled instruction and any pending output. A parcel tagged as an entry point starts its instruction with no mode bits left. Each instruction leaves through a one-entry output register with its data, a width flag, a kind tag and the number of mode bits still left.

The sequencer has two states:
- `ST_HEAD` waits for the first parcel of an instruction.
- `ST_TAIL` holds the first half of a two-parcel instruction.

It moves between them on these transitions:
- HEAD→HEAD when a compressed parcel is accepted.
- HEAD→TAIL when the first half of a two-parcel instruction is accepted.
- TAIL→HEAD when the second half is accepted.
- any→HEAD on `branch_taken`.

Top module: `cmode_seq`

## Requirements
- R1: A parcel transfers only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is low while `branch_taken` is high, and low while `out_valid` is high and `out_ready` is low.
- R2: With no mode bits left, an instruction takes two parcels. It leaves with `out_kind`=0 (uncompressed) and `out_wide`=1. The first parcel appears in `out_data[31:16]` and the second in `out_data[15:0]`.
- R3: A two-parcel instruction whose first parcel has bits [15:10] equal to 6'b111011 is a prefix. It leaves with `out_kind`=2, `out_wide`=1 and both parcels in `out_data` as in R2. It loads bits [9:0] of its first parcel as the new mode mask and reports `out_left`=10.
- R4: Mask bits are used MSB first, so bit 9 governs the first instruction after the prefix. A 1 makes that instruction a single parcel, leaving with `out_kind`=1, `out_wide`=0 and `out_data`={16'h0000, parcel}. A 0 makes it two parcels.
- R5: `out_left` reports the mode bits still unused after this instruction's own bit is taken.
- R6: Once all ten bits are used, instructions take two parcels until another prefix arrives.
- R7: A prefix arriving while bits remain replaces them; the old bits are not kept after the new ones.
- R8: `branch_taken` clears the held output (`out_valid` low next cycle), discards a held first half, and clears all mode bits.
- R9: `in_entry` high on the first parcel of an instruction clears the mode bits before that instruction is sized, so it takes two parcels. On a second parcel, `in_entry` has no effect.
- R10: While `out_valid` is high and `out_ready` is low, with no taken branch, all output fields hold steady.
- R11: After reset, `out_valid` is low, `in_ready` is high and no mode bits remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel can be taken this cycle |
| in_parcel | input | 16 | Fetched parcel |
| in_entry | input | 1 | Parcel starts an entry-point instruction |
| branch_taken | input | 1 | Taken branch: flush stream state |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | 32 | Instruction bits (single parcel in low half) |
| out_wide | output | 1 | Instruction used two parcels |
| out_kind | output | 2 | 0 uncompressed, 1 compressed, 2 prefix with embedded compressed |
| out_left | output | 4 | Mode bits remaining after this instruction |

## Verification
Two functions can fall in the same cycle. A taken branch can arrive while a parcel is on offer and an instruction waits in the output register. The bench provokes this by holding `out_ready` low after a prefix, or by parking the first half of a wide instruction, and then raising `branch_taken` together with `in_valid`. It then judges three things: the offered parcel is refused, the waiting output vanishes, and the next two parcels form one uncompressed instruction with no leftover half. Entry tags are also placed on first and second parcels of mask-governed slots, so a wrong clear shows up as a wrongly sized next instruction.

// File: rtl/cmode_pkg.sv
package cmode_pkg;

    typedef enum logic [1:0] {
        K_UNC = 2'd0,
        K_CMP = 2'd1,
        K_PFX = 2'd2
    } ikind_e;

    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_TAIL = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cmode_mask.sv
// Mode mask tracker: holds the active mask and the count of unused bits.
module cmode_mask #(
    parameter int MODE_N = 10,
    localparam int CNT_W = $clog2(MODE_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [MODE_N-1:0] load_bits,
    input  logic              drop,
    input  logic              take,
    output logic              bit_now,
    output logic [CNT_W-1:0]  left
);

    logic [MODE_N-1:0] mask_q;
    logic [CNT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            left_q <= '0;
        end else if (flush) begin
            left_q <= '0;
        end else if (load) begin
            mask_q <= load_bits;
            left_q <= CNT_W'(MODE_N);
        end else if (drop) begin
            left_q <= '0;
        end else if (take) begin
            mask_q <= mask_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_now = mask_q[MODE_N-1];
    assign left    = left_q;

endmodule

// File: rtl/cmode_fsm.sv
// Parcel sequencer: sizes each instruction and assembles two-parcel ones.
module cmode_fsm
    import cmode_pkg::*;
#(
    parameter int PARCEL_W = 16,
    parameter int OPC_W    = 6,
    parameter int MODE_N   = 10,
    parameter logic [OPC_W-1:0] PFX_OPC = 6'b111011,
    localparam int CNT_W  = $clog2(MODE_N + 1),
    localparam int INSN_W = 2 * PARCEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                in_valid,
    input  logic [PARCEL_W-1:0] in_parcel,
    input  logic                in_entry,
    input  logic                slot_free,
    output logic                in_ready,
    input  logic [CNT_W-1:0]    mb_left,
    input  logic                mb_bit,
    output logic                mb_drop,
    output logic                mb_take,
    output logic                mb_load,
    output logic [MODE_N-1:0]   mb_bits,
    output logic                emit,
    output logic [INSN_W-1:0]   emit_data,
    output logic                emit_wide,
    output ikind_e              emit_kind,
    output logic [CNT_W-1:0]    emit_left
);

    seq_state_e          st_q, st_d;
    logic [PARCEL_W-1:0] held_q;
    logic                acc;
    logic [CNT_W-1:0]    live_left;
    logic                short_slot;
    logic                held_is_pfx;

    assign in_ready = slot_free && !flush;
    assign acc      = in_valid && in_ready;

    always_comb begin
        live_left   = in_entry ? '0 : mb_left;
        short_slot  = (live_left != '0) && mb_bit;
        held_is_pfx = (held_q[PARCEL_W-1 -: OPC_W] == PFX_OPC);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HEAD;
        end else begin
            st_q <= st_d;
        end
    end

    // first-half carry buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (acc && (st_q == ST_HEAD)) begin
            held_q <= in_parcel;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = ST_HEAD;
        end else if (acc) begin
            unique case (st_q)
                ST_HEAD: if (!short_slot) st_d = ST_TAIL;
                ST_TAIL: st_d = ST_HEAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        mb_drop   = 1'b0;
        mb_take   = 1'b0;
        mb_load   = 1'b0;
        mb_bits   = held_q[MODE_N-1:0];
        emit      = 1'b0;
        emit_data = '0;
        emit_wide = 1'b0;
        emit_kind = K_UNC;
        emit_left = '0;
        if (acc) begin
            unique case (st_q)
                ST_HEAD: begin
                    mb_drop = in_entry;
                    mb_take = (live_left != '0);
                    if (short_slot) begin
                        emit      = 1'b1;
                        emit_data = {{PARCEL_W{1'b0}}, in_parcel};
                        emit_wide = 1'b0;
                        emit_kind = K_CMP;
                        emit_left = live_left - 1'b1;
                    end
                end
                ST_TAIL: begin
                    emit      = 1'b1;
                    emit_data = {held_q, in_parcel};
                    emit_wide = 1'b1;
                    if (held_is_pfx) begin
                        mb_load   = 1'b1;
                        emit_kind = K_PFX;
                        emit_left = CNT_W'(MODE_N);
                    end else begin
                        emit_kind = K_UNC;
                        emit_left = mb_left;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cmode_oslot.sv
// One-entry output register with valid/ready.
module cmode_oslot
    import cmode_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              emit,
    input  logic [INSN_W-1:0] emit_data,
    input  logic              emit_wide,
    input  ikind_e            emit_kind,
    input  logic [CNT_W-1:0]  emit_left,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_data,
    output logic              out_wide,
    output logic [1:0]        out_kind,
    output logic [CNT_W-1:0]  out_left
);

    logic vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (flush) begin
            vld_q <= 1'b0;
        end else if (emit) begin
            vld_q <= 1'b1;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_wide <= 1'b0;
            out_kind <= 2'd0;
            out_left <= '0;
        end else if (emit && !flush) begin
            out_data <= emit_data;
            out_wide <= emit_wide;
            out_kind <= emit_kind;
            out_left <= emit_left;
        end
    end

    assign out_valid = vld_q;
    assign slot_free = !vld_q || out_ready;

endmodule

// File: rtl/cmode_seq.sv
// Top: compressed-mode instruction stream sequencer.
module cmode_seq
    import cmode_pkg::*;
#(
    parameter int PARCEL_W = 16,
    parameter int OPC_W    = 6,
    parameter int MODE_N   = 10,
    parameter logic [OPC_W-1:0] PFX_OPC = 6'b111011,
    localparam int CNT_W  = $clog2(MODE_N + 1),
    localparam int INSN_W = 2 * PARCEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PARCEL_W-1:0] in_parcel,
    input  logic                in_entry,
    input  logic                branch_taken,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [INSN_W-1:0]   out_data,
    output logic                out_wide,
    output logic [1:0]          out_kind,
    output logic [CNT_W-1:0]    out_left
);

    logic              mode_bit;
    logic [CNT_W-1:0]  mode_left;
    logic              mb_drop, mb_take, mb_load;
    logic [MODE_N-1:0] mb_bits;
    logic              slot_free;
    logic              emit;
    logic [INSN_W-1:0] emit_data;
    logic              emit_wide;
    ikind_e            emit_kind;
    logic [CNT_W-1:0]  emit_left;

    cmode_mask #(.MODE_N(MODE_N)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (branch_taken),
        .load      (mb_load),
        .load_bits (mb_bits),
        .drop      (mb_drop),
        .take      (mb_take),
        .bit_now   (mode_bit),
        .left      (mode_left)
    );

    cmode_fsm #(
        .PARCEL_W (PARCEL_W),
        .OPC_W    (OPC_W),
        .MODE_N   (MODE_N),
        .PFX_OPC  (PFX_OPC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (branch_taken),
        .in_valid  (in_valid),
        .in_parcel (in_parcel),
        .in_entry  (in_entry),
        .slot_free (slot_free),
        .in_ready  (in_ready),
        .mb_left   (mode_left),
        .mb_bit    (mode_bit),
        .mb_drop   (mb_drop),
        .mb_take   (mb_take),
        .mb_load   (mb_load),
        .mb_bits   (mb_bits),
        .emit      (emit),
        .emit_data (emit_data),
        .emit_wide (emit_wide),
        .emit_kind (emit_kind),
        .emit_left (emit_left)
    );

    cmode_oslot #(.INSN_W(INSN_W), .CNT_W(CNT_W)) u_oslot (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (branch_taken),
        .emit      (emit),
        .emit_data (emit_data),
        .emit_wide (emit_wide),
        .emit_kind (emit_kind),
        .emit_left (emit_left),
        .out_ready (out_ready),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_wide  (out_wide),
        .out_kind  (out_kind),
        .out_left  (out_left)
    );

endmodule

// File: rtl/cmode_seq_chk.sv
module cmode_seq_chk
    import cmode_pkg::*;
#(
    parameter int MODE_N = 10,
    parameter int CNT_W  = 4,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              branch_taken,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [INSN_W-1:0] out_data,
    input logic              out_wide,
    input logic [1:0]        out_kind,
    input logic [CNT_W-1:0]  out_left,
    input logic [CNT_W-1:0]  mode_left
);

    p_flush_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> !in_ready);

    p_full_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_prefix_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_PFX) |-> (out_wide && out_left == CNT_W'(MODE_N)));

    p_compressed_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_CMP) |-> (!out_wide && out_data[INSN_W-1:INSN_W/2] == '0));

    p_left_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != K_PFX) |-> (out_left < CNT_W'(MODE_N)));

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |=> (!out_valid && mode_left == '0));

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !branch_taken) |=>
        (out_valid && $stable(out_data) && $stable(out_kind) &&
         $stable(out_left) && $stable(out_wide)));

    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'd3));

endmodule

bind cmode_seq cmode_seq_chk #(.MODE_N(MODE_N), .CNT_W(CNT_W), .INSN_W(INSN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .branch_taken (branch_taken),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_wide     (out_wide),
    .out_kind     (out_kind),
    .out_left     (out_left),
    .mode_left    (mode_left)
);

// File: tb/test_cmode_seq.sv
module test_cmode_seq;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] PFX = 6'b111011;

    typedef struct packed {
        logic [31:0] d;
        logic        w;
        logic [1:0]  k;
        logic [3:0]  l;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_parcel = '0;
    logic        in_entry = 1'b0;
    logic        branch_taken = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_wide;
    logic [1:0]  out_kind;
    logic [3:0]  out_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmode_seq i_cmode_seq (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_parcel (in_parcel),
        .in_entry (in_entry), .branch_taken (branch_taken),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_wide (out_wide), .out_kind (out_kind), .out_left (out_left)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic rec_t mk(input logic [31:0] d, input logic w, input logic [1:0] k, input int l);
        rec_t r;
        r.d = d; r.w = w; r.k = k; r.l = 4'(l);
        return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    rec_t        mq[$];
    rec_t        got[$];
    int          m_left = 0;
    logic [9:0]  m_mask = '0;
    bit          m_half = 0;
    logic [15:0] m_held = '0;
    bit          acc_seen = 0;
    bit          hold_prev = 0;
    rec_t        prev_rec;

    always @(posedge clk) begin
        acc_seen = in_valid && in_ready;
        hold_prev = rst_n && out_valid && !out_ready && !branch_taken;
        prev_rec = mk(out_data, out_wide, out_kind, int'(out_left));
        if (!rst_n) begin
            mq.delete(); m_left = 0; m_half = 0;
        end else if (branch_taken) begin
            mq.delete(); m_left = 0; m_half = 0;
        end else begin
            if (out_valid && out_ready) begin
                got.push_back(mk(out_data, out_wide, out_kind, int'(out_left)));
                if (mq.size() != 0) void'(mq.pop_front());
            end
            if (in_valid && in_ready) begin
                if (!m_half) begin
                    int lv;
                    lv = in_entry ? 0 : m_left;
                    if (lv > 0 && m_mask[9]) begin
                        m_mask = m_mask << 1; m_left = lv - 1;
                        mq.push_back(mk({16'h0000, in_parcel}, 1'b0, 2'd1, m_left));
                    end else begin
                        if (lv > 0) begin m_mask = m_mask << 1; m_left = lv - 1; end
                        else m_left = 0;
                        m_held = in_parcel; m_half = 1;
                    end
                end else begin
                    m_half = 0;
                    if (m_held[15:10] == PFX) begin
                        m_mask = m_held[9:0]; m_left = 10;
                        mq.push_back(mk({m_held, in_parcel}, 1'b1, 2'd2, 10));
                    end else begin
                        mq.push_back(mk({m_held, in_parcel}, 1'b1, 2'd0, m_left));
                    end
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            rec_t a;
            a = mk(out_data, out_wide, out_kind, int'(out_left));
            check(out_valid == (mq.size() != 0), "R8 valid", 64'(out_valid), 64'(mq.size() != 0));
            if (out_valid && mq.size() != 0) begin
                check(a == mq[0], mq[0].k == 2'd2 ? "R3" : (mq[0].k == 2'd1 ? "R4" : "R2"),
                      64'(a), 64'(mq[0]));
                check(a.l == mq[0].l, "R5", 64'(a.l), 64'(mq[0].l));
            end
            if (hold_prev) check(a == prev_rec, "R10", 64'(a), 64'(prev_rec));
        end
    end

    // out_ready driver
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
    end

    task automatic send(input logic [15:0] p, input bit ent);
        in_parcel = p; in_entry = ent; in_valid = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (acc_seen) break;
        end
        @(negedge clk);
        in_valid = 1'b0; in_entry = 1'b0;
    endtask

    task automatic flush(input bit with_parcel, input logic [15:0] p);
        branch_taken = 1'b1;
        if (with_parcel) begin in_valid = 1'b1; in_parcel = p; end
        #1;
        check(in_ready == 1'b0, "R1 flush refuses parcel", 64'(in_ready), 64'(0));
        @(negedge clk);
        branch_taken = 1'b0; in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_at(input int idx, input rec_t e, input string req);
        if (idx < got.size()) check(got[idx] == e, req, 64'(got[idx]), 64'(e));
        else check(1'b0, req, 64'(got.size()), 64'(idx + 1));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11 out_valid in reset", 64'(out_valid), 64'(0));
        check(in_ready == 1'b1, "R11 in_ready in reset", 64'(in_ready), 64'(1));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'(0));

        // R2, R11: plain two-parcel instruction
        base = got.size();
        send(16'h1234, 0); send(16'h5678, 0); settle();
        expect_at(base, mk(32'h12345678, 1, 2'd0, 0), "R2 uncompressed after reset (R11)");

        // R3, R4, R5, R6: mask 10'b1010000001
        base = got.size();
        send({PFX, 10'b1010000001}, 0); send(16'hABCD, 0);
        send(16'h1111, 0);
        send(16'h2222, 0); send(16'h3333, 0);
        send(16'h4444, 0);
        for (int i = 0; i < 6; i++) begin send(16'h0100 + 16'(i), 0); send(16'h0200 + 16'(i), 0); end
        send(16'h5555, 0);
        send(16'h6666, 0); send(16'h7777, 0);
        settle();
        expect_at(base,      mk({PFX, 10'b1010000001, 16'hABCD}, 1, 2'd2, 10), "R3 prefix");
        expect_at(base + 1,  mk(32'h00001111, 0, 2'd1, 9), "R4 first bit compressed");
        expect_at(base + 2,  mk(32'h22223333, 1, 2'd0, 8), "R4 zero bit wide");
        expect_at(base + 3,  mk(32'h00004444, 0, 2'd1, 7), "R5 count");
        expect_at(base + 9,  mk(32'h01050205, 1, 2'd0, 1), "R5 count near end");
        expect_at(base + 10, mk(32'h00005555, 0, 2'd1, 0), "R4 last bit");
        expect_at(base + 11, mk(32'h66667777, 1, 2'd0, 0), "R6 exhausted mask");

        // R7: new prefix replaces remaining bits
        base = got.size();
        send({PFX, 10'b0100000000}, 0); send(16'h0A0A, 0);
        send({PFX, 10'b0000000000}, 0); send(16'h9999, 0);
        send(16'h1357, 0); send(16'h2468, 0);
        settle();
        expect_at(base + 1, mk({PFX, 10'b0000000000, 16'h9999}, 1, 2'd2, 10), "R7 prefix reload");
        expect_at(base + 2, mk(32'h13572468, 1, 2'd0, 9), "R7 old bits discarded");
        flush(0, 16'h0);

        // R8, R1: flush drops a held output
        rdy_mode = 2; @(negedge clk);
        base = got.size();
        send({PFX, 10'b1111111111}, 0); send(16'h0001, 0);
        #1;
        check(out_valid == 1'b1, "R10 output held while stalled", 64'(out_valid), 64'(1));
        check(in_ready == 1'b0, "R1 full slot refuses parcel", 64'(in_ready), 64'(0));
        @(negedge clk);
        flush(1, 16'h0C0C);
        check(out_valid == 1'b0, "R8 held output dropped", 64'(out_valid), 64'(0));
        rdy_mode = 0; settle();
        check(got.size() == base, "R8 no output after flush", 64'(got.size()), 64'(base));

        // R8: flush discards held half and mode bits
        base = got.size();
        send({PFX, 10'b0111111111}, 0); send(16'h0002, 0);
        send(16'h0BBB, 0);
        flush(1, 16'h0CCC);
        send(16'h0DDD, 0); send(16'h0EEE, 0);
        settle();
        expect_at(base + 1, mk(32'h0DDD0EEE, 1, 2'd0, 0), "R8 carry and bits discarded");

        // R9: entry point forces uncompressed; ignored on second parcel
        base = got.size();
        send({PFX, 10'b1111111111}, 0); send(16'h0003, 0);
        send(16'h0111, 1); send(16'h0222, 1);
        send(16'h0333, 0); send(16'h0444, 0);
        send({PFX, 10'b0100000000}, 0); send(16'h0004, 0);
        send(16'h0555, 0); send(16'h0666, 1);
        send(16'h0777, 0);
        settle();
        expect_at(base + 1, mk(32'h01110222, 1, 2'd0, 0), "R9 entry clears bits");
        expect_at(base + 2, mk(32'h03330444, 1, 2'd0, 0), "R9 stays uncompressed");
        expect_at(base + 4, mk(32'h05550666, 1, 2'd0, 9), "R9 entry on second parcel ignored");
        expect_at(base + 5, mk(32'h00000777, 0, 2'd1, 8), "R9 next slot still compressed");

        // mixed stream under random back-pressure (R1 R2 R3 R4 R5 R10)
        rdy_mode = 1;
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            if (r % 23 == 0) flush(r[8], 16'(r >> 9));
            else if (r % 5 == 0) send({PFX, 10'(r >> 5)}, r % 11 == 0);
            else send(16'(r >> 3), r % 13 == 0);
        end
        rdy_mode = 0; settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule